// File: doc/BRIEF.md
# Nested Core Event Controller

This block arbitrates a fixed set of core event levels, 16 by default, and tracks how far handlers are nested. Each level has one bit in three state registers. A capture register records rising edges seen on the event inputs. An enable register decides which captured levels may be serviced. An active register records which handlers the core has entered and not yet left. Low indices are the top levels. Levels from a configurable index upward are general-purpose levels, and a single global enable gates all of them together.

The controller compares two things: the best serviceable captured level, and the best level that is already active. When the captured level wins, the controller raises a request to the core and gives the level index. The core answers with an accept strobe. The accept marks the level active and clears its capture bit, so a later edge on the same input can be queued while that handler runs. A return strobe retires the top active level. A register port gives access to the three registers, and only supervisor-mode accesses are honoured.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the capture, enable and active registers read zero, the global enable is off and no request is raised.
- R2: A rising edge on an event input sets its capture bit on the second clock edge that samples the input high. An input held high sets the bit only once.
- R3: An accept clears the capture bit of the accepted level in the same edge that sets its active bit. A new rising edge on that input while the level is active sets the capture bit again.
- R4: A captured level with a 0 enable bit stays captured and never produces a request. An enable bit of 1 allows service.
- R5: A supervisor write to the capture register (select code 0) changes only the bits whose enable bit is 0. Bits whose enable bit is 1 keep their value.
- R6: Levels at or above index GP_BASE are serviceable only while the global enable is on. The global enable turns on with a set strobe and off with a clear strobe. The clear strobe wins when both come together.
- R7: The request names the lowest-index captured, enabled and gated level. It is raised only when that index is below every set active bit.
- R8: An accept while a request is up sets the active bit of the requested level and keeps the active bits already set, so nested levels stay recorded. An accept with no request has no effect.
- R9: A return strobe clears the lowest-index set active bit and leaves the others.
- R10: Register select codes are 0 capture, 1 enable, 2 active and 3 unused. Code 3 reads zero, and the active register cannot be written. With supervisor mode low, writes are ignored and reads return zero.
- R11: With an accept given as soon as the request appears, the active bit of a level is set on the third clock edge after its input first goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | Event inputs, one for each level, edge sensitive |
| sup_mode | input | 1 | Qualifies register accesses as supervisor accesses |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 capture, 1 enable, 2 active, 3 unused |
| reg_wdata | input | NUM_EVT | Register write data |
| reg_rdata | output | NUM_EVT | Read data for the selected register |
| gie_on | input | 1 | Strobe that turns the global enable on |
| gie_off | input | 1 | Strobe that turns the global enable off |
| irq_req | output | 1 | Request to the core to enter a handler |
| irq_idx | output | $clog2(NUM_EVT) | Index of the requested level |
| irq_accept | input | 1 | Core accepts the requested level |
| irq_return | input | 1 | Core returns from the top active handler |

## Verification
The bench builds the block with 16 levels, GP_BASE set to 6 and a single synchronizer stage. This puts the general-purpose boundary inside the levels the directed nesting cases use, so global gating, preemption across that boundary and the exact three-edge latency can all be checked. The random phase mixes sparse edges, accepts, returns, global-enable strobes and register writes in every mode. This reaches accepts with no request, writes to the active register, writes to capture bits that are only partly enabled, and deep nesting.

// File: rtl/nec_pkg.sv
package nec_pkg;

   typedef enum logic [1:0] {
      SEL_CAPT = 2'd0,
      SEL_ENAB = 2'd1,
      SEL_ACTV = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/nec_edge.sv
module nec_edge #(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig_in,
   output logic [W-1:0] rise
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0][W-1:0] sync_q;
   logic [W-1:0]                  hist_q;

   genvar k;
   generate
      for (k = 0; k < SYNC_STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[k] <= '0;
               else        sync_q[k] <= sig_in;
            end
         end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[k] <= '0;
               else        sync_q[k] <= sync_q[k-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= sync_q[LAST];
   end

   assign rise = sync_q[LAST] & ~hist_q;

   // a level held high gives one pulse only
   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/nec_first.sv
module nec_first #(
   parameter int W = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          hit,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int k = W - 1; k >= 0; k--) begin
         if (vec[k]) idx = IW'(k);
      end
   end

   assign hit = |vec;

   always_comb begin
      if (hit) assert_idx_set_R7: assert (vec[idx]);
   end

endmodule

// File: rtl/nec_capture.sv
module nec_capture #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rise,
   input  logic [W-1:0] enab,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] take,
   output logic [W-1:0] capt_q
);
   logic [W-1:0] capt_d;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         logic keep;
         assign keep      = (wr_en && !enab[i]) ? wdata[i] : capt_q[i];
         assign capt_d[i] = rise[i] | (keep & ~take[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) capt_q <= '0;
      else        capt_q <= capt_d;
   end

   assert_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|take) |=> ((capt_q & $past(take) & ~$past(rise)) == '0));

   assert_enabled_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (((capt_q ^ $past(capt_q)) & $past(enab) & ~$past(take) & ~$past(rise)) == '0));

endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl #(
   parameter int NUM_EVT     = 16,
   parameter int GP_BASE     = 7,
   parameter int SYNC_STAGES = 1,
   localparam int IW = $clog2(NUM_EVT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               sup_mode,
   input  logic               reg_we,
   input  logic [1:0]         reg_sel,
   input  logic [NUM_EVT-1:0] reg_wdata,
   output logic [NUM_EVT-1:0] reg_rdata,
   input  logic               gie_on,
   input  logic               gie_off,
   output logic               irq_req,
   output logic [IW-1:0]      irq_idx,
   input  logic               irq_accept,
   input  logic               irq_return
);
   import nec_pkg::*;

   generate
      if (NUM_EVT < 2 || NUM_EVT > 32) begin : g_bad_num
         $error("NUM_EVT must be within 2..32");
      end
      if (GP_BASE < 0 || GP_BASE > NUM_EVT) begin : g_bad_gp
         $error("GP_BASE must be within 0..NUM_EVT");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   localparam logic [NUM_EVT-1:0] ONE = NUM_EVT'(1);

   reg_sel_e           sel;
   logic               wr_ok;
   logic [NUM_EVT-1:0] rise;
   logic [NUM_EVT-1:0] capt_q;
   logic [NUM_EVT-1:0] enab_q;
   logic [NUM_EVT-1:0] actv_q, actv_d;
   logic               gie_q;
   logic [NUM_EVT-1:0] gate;
   logic [NUM_EVT-1:0] ready;
   logic               cand_hit, actv_hit;
   logic [IW-1:0]      cand_idx, actv_idx;
   logic [NUM_EVT-1:0] req_oh, take_oh, top_oh, req_upto;

   assign sel   = reg_sel_e'(reg_sel);
   assign wr_ok = reg_we && sup_mode;

   nec_edge #(.W(NUM_EVT), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (evt_in),
      .rise   (rise)
   );

   nec_capture #(.W(NUM_EVT)) u_capt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .enab   (enab_q),
      .wr_en  (wr_ok && sel == SEL_CAPT),
      .wdata  (reg_wdata),
      .take   (take_oh),
      .capt_q (capt_q)
   );

   // enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        enab_q <= '0;
      else if (wr_ok && sel == SEL_ENAB) enab_q <= reg_wdata;
   end

   // global enable for general-purpose levels, clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gie_q <= 1'b0;
      else if (gie_off) gie_q <= 1'b0;
      else if (gie_on)  gie_q <= 1'b1;
   end

   genvar g;
   generate
      for (g = 0; g < NUM_EVT; g++) begin : g_gate
         if (g < GP_BASE) begin : g_core
            assign gate[g] = 1'b1;
         end else begin : g_gp
            assign gate[g] = gie_q;
         end
      end
   endgenerate

   assign ready = capt_q & enab_q & gate;

   nec_first #(.W(NUM_EVT)) u_cand (
      .vec (ready),
      .hit (cand_hit),
      .idx (cand_idx)
   );

   nec_first #(.W(NUM_EVT)) u_top (
      .vec (actv_q),
      .hit (actv_hit),
      .idx (actv_idx)
   );

   assign irq_req  = cand_hit && (!actv_hit || cand_idx < actv_idx);
   assign irq_idx  = cand_idx;
   assign req_oh   = ONE << cand_idx;
   assign take_oh  = (irq_accept && irq_req) ? req_oh : '0;
   assign top_oh   = actv_hit ? (ONE << actv_idx) : '0;
   assign req_upto = req_oh | (req_oh - ONE);

   // active (nesting) register
   always_comb begin
      actv_d = actv_q;
      if (irq_return) actv_d = actv_d & ~top_oh;
      actv_d = actv_d | take_oh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) actv_q <= '0;
      else        actv_q <= actv_d;
   end

   // register read port
   always_comb begin
      reg_rdata = '0;
      if (sup_mode) begin
         unique case (sel)
            SEL_CAPT: reg_rdata = capt_q;
            SEL_ENAB: reg_rdata = enab_q;
            SEL_ACTV: reg_rdata = actv_q;
            SEL_NONE: reg_rdata = '0;
         endcase
      end
   end

   assert_req_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((enab_q & capt_q & req_oh) != '0));

   assert_gp_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !gie_q) |-> (int'(irq_idx) < GP_BASE));

   assert_preempt_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((actv_q & req_upto) == '0));

   assert_accept_nests_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept && irq_req && !irq_return) |=>
         ((actv_q & ($past(actv_q) | $past(req_oh))) == ($past(actv_q) | $past(req_oh))));

   assert_return_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && !irq_accept && actv_q != '0) |=>
         ($countones(actv_q) == $countones($past(actv_q)) - 1));

   assert_user_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_mode |-> (reg_rdata == '0));

endmodule

// File: tb/evt_nest_ctrl_bench.sv
`timescale 1ns/1ps
module evt_nest_ctrl_bench;
   localparam int N   = 16;
   localparam int GPF = 6;
   localparam int NONE = 99;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt_in = '0;
   logic          sup_mode = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [N-1:0]  reg_wdata = '0;
   logic [N-1:0]  reg_rdata;
   logic          gie_on = 1'b0, gie_off = 1'b0;
   logic          irq_req;
   logic [3:0]    irq_idx;
   logic          irq_accept = 1'b0, irq_return = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evt_nest_ctrl #(.NUM_EVT(N), .GP_BASE(GPF), .SYNC_STAGES(1)) u_evt_nest_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sup_mode(sup_mode),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .gie_on(gie_on), .gie_off(gie_off), .irq_req(irq_req), .irq_idx(irq_idx),
      .irq_accept(irq_accept), .irq_return(irq_return)
   );

   // ---------------- reference model ----------------
   logic [N-1:0] m_sync = '0, m_hist = '0, m_capt = '0, m_enab = '0, m_actv = '0;
   logic         m_gie = 1'b0;

   function automatic int first_set(logic [N-1:0] v);
      for (int k = 0; k < N; k++) if (v[k]) return k;
      return NONE;
   endfunction

   function automatic int m_cand();
      logic [N-1:0] g;
      g = m_gie ? '1 : N'((1 << GPF) - 1);
      return first_set(m_capt & m_enab & g);
   endfunction

   function automatic bit m_req();
      int c;
      c = m_cand();
      return (c != NONE) && (c < first_set(m_actv));
   endfunction

   function automatic logic [N-1:0] m_read(bit sup, logic [1:0] sel);
      if (!sup) return '0;
      case (sel)
         2'd0:    return m_capt;
         2'd1:    return m_enab;
         2'd2:    return m_actv;
         default: return '0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sync = '0; m_hist = '0; m_capt = '0; m_enab = '0; m_actv = '0; m_gie = 1'b0;
      end else begin
         logic [N-1:0] rs;
         bit           rq;
         int           c, p;
         rs = m_sync & ~m_hist;
         rq = m_req();
         c  = m_cand();
         p  = first_set(m_actv);
         if (reg_we && sup_mode && reg_sel == 2'd0)
            m_capt = (m_capt & m_enab) | (reg_wdata & ~m_enab);
         if (irq_accept && rq) m_capt[c] = 1'b0;
         m_capt = m_capt | rs;
         if (reg_we && sup_mode && reg_sel == 2'd1) m_enab = reg_wdata;
         if (irq_return && p != NONE) m_actv[p] = 1'b0;
         if (irq_accept && rq) m_actv[c] = 1'b1;
         if (gie_off) m_gie = 1'b0;
         else if (gie_on) m_gie = 1'b1;
         m_hist = m_sync;
         m_sync = evt_in;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0; irq_accept = 1'b0; irq_return = 1'b0; gie_on = 1'b0; gie_off = 1'b0;
      #0.5;
      chk("R7 request vs model", irq_req, m_req());
      if (m_req()) chk("R7 index vs model", irq_idx, m_cand());
   endtask

   task automatic wr(logic [1:0] sel, logic [N-1:0] d, bit sup);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d; sup_mode = sup;
      cyc();
      sup_mode = 1'b1;
   endtask

   task automatic rd(string tag, logic [1:0] sel, bit sup, logic [N-1:0] exp);
      reg_sel = sel; sup_mode = sup;
      #0.5;
      chk(tag, reg_rdata, exp);
      chk({tag, " model"}, reg_rdata, m_read(sup, sel));
      sup_mode = 1'b1;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 5);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int unsigned seed;
      seed = 32'h1A2B3C;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sup_mode = 1'b1;
      #0.5;
      // R1 reset state
      chk("R1 no request", irq_req, 0);
      rd("R1 capture zero", 2'd0, 1, '0);
      rd("R1 enable zero", 2'd1, 1, '0);
      rd("R1 active zero", 2'd2, 1, '0);

      // R10 user mode
      wr(2'd1, 16'hFFFF, 0);
      rd("R10 user write ignored", 2'd1, 1, 16'h0000);
      wr(2'd1, 16'h00FF, 1);
      rd("R10 user read zero", 2'd1, 0, 16'h0000);
      rd("R10 unused select", 2'd3, 1, 16'h0000);
      wr(2'd2, 16'hFFFF, 1);
      rd("R10 active not writable", 2'd2, 1, 16'h0000);

      // R5 / R4 / R6
      wr(2'd0, 16'hFFFF, 1);
      rd("R5 only disabled bits written", 2'd0, 1, 16'hFF00);
      chk("R4 disabled captured no request", irq_req, 0);
      wr(2'd1, 16'hFFFF, 1);
      chk("R6 gp level gated off", irq_req, 0);
      gie_on = 1'b1; cyc();
      chk("R6 gp level after enable", irq_req, 1);
      chk("R7 lowest index", irq_idx, 8);
      wr(2'd0, 16'h0000, 1);
      rd("R5 enabled bits locked", 2'd0, 1, 16'hFF00);
      wr(2'd1, 16'h0000, 1);
      wr(2'd0, 16'h0000, 1);
      rd("R5 clear disabled bits", 2'd0, 1, 16'h0000);
      wr(2'd1, 16'hFFFF, 1);

      // R2 / R11 / R3 latency and queueing
      evt_in[3] = 1'b1;
      cyc();
      rd("R2 not captured after one edge", 2'd0, 1, 16'h0000);
      cyc();
      rd("R2 captured on second edge", 2'd0, 1, 16'h0008);
      chk("R7 request level 3", irq_req, 1);
      chk("R7 index 3", irq_idx, 3);
      irq_accept = 1'b1; cyc();
      rd("R11 active on third edge", 2'd2, 1, 16'h0008);
      rd("R3 capture cleared by accept", 2'd0, 1, 16'h0000);
      cyc(); cyc(); cyc();
      rd("R2 held level no recapture", 2'd0, 1, 16'h0000);
      evt_in[3] = 1'b0; cyc();
      evt_in[3] = 1'b1; cyc(); cyc();
      rd("R3 edge queued while active", 2'd0, 1, 16'h0008);
      chk("R7 same level no preempt", irq_req, 0);
      evt_in[1] = 1'b1; cyc(); cyc();
      chk("R7 higher level preempts", irq_req, 1);
      chk("R7 preempt index", irq_idx, 1);
      irq_accept = 1'b1; cyc();
      rd("R8 nested active", 2'd2, 1, 16'h000A);
      irq_accept = 1'b1; cyc();
      rd("R8 accept without request ignored", 2'd2, 1, 16'h000A);
      irq_return = 1'b1; cyc();
      rd("R9 return clears top", 2'd2, 1, 16'h0008);
      chk("R7 blocked by active 3", irq_req, 0);
      irq_return = 1'b1; cyc();
      rd("R9 all returned", 2'd2, 1, 16'h0000);
      chk("R3 queued edge requests", irq_req, 1);
      chk("R3 queued index", irq_idx, 3);
      irq_accept = 1'b1; cyc();
      irq_return = 1'b1; cyc();
      evt_in = '0; cyc();

      // R6 clear wins
      gie_on = 1'b1; gie_off = 1'b1; cyc();
      evt_in[10] = 1'b1; cyc(); cyc();
      rd("R6 gp captured", 2'd0, 1, 16'h0400);
      chk("R6 clear wins", irq_req, 0);
      gie_on = 1'b1; cyc();
      chk("R6 re-enabled request", irq_req, 1);
      chk("R6 re-enabled index", irq_idx, 10);
      irq_accept = 1'b1; cyc();
      irq_return = 1'b1; cyc();
      evt_in = '0; cyc();

      // random phase
      for (int t = 0; t < 4000; t++) begin
         bit r;
         evt_in = evt_in ^ (N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom));
         r = m_req();
         irq_accept = r ? ($urandom % 3 == 0) : ($urandom % 16 == 0);
         irq_return = ($urandom % 7 == 0);
         gie_on  = ($urandom % 24 == 0);
         gie_off = ($urandom % 40 == 0);
         if ($urandom % 12 == 0) begin
            reg_we = 1'b1;
            reg_sel = 2'($urandom);
            reg_wdata = N'($urandom);
            sup_mode = ($urandom % 4 != 0);
         end
         @(posedge clk);
         @(negedge clk);
         reg_we = 1'b0; irq_accept = 1'b0; irq_return = 1'b0; gie_on = 1'b0; gie_off = 1'b0;
         reg_sel = 2'($urandom);
         sup_mode = ($urandom % 5 != 0);
         #0.5;
         chk("R7 random request", irq_req, m_req());
         if (m_req()) chk("R7 random index", irq_idx, m_cand());
         chk("R10 random read", reg_rdata, m_read(sup_mode, reg_sel));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule